// File: doc/BRIEF.md
# Dual-Clock Up/Down Counter Stage

This block is a small binary counter that steps up on a rising edge of one clock-like input and down on a rising edge of another. Both are ordinary asynchronous signals sampled by a fast system clock. Each count input passes through a multi-flop synchroniser and an edge detector. The count then advances on the system clock, so every register in the block sits in one clock domain.

A low-active load copies a data word into the count, and a high-active clear forces it to zero. Clear has priority over load, and load has priority over counting. Both control inputs are synchronised the same way as the count inputs.

Two low-active terminal outputs track the count. The carry output goes low while the count is at its maximum and the up input is low. The borrow output goes low while the count is zero and the down input is low. Each terminal output therefore copies the low phase of its clock at the wrap point. Feeding them into the up and down inputs of a second stage builds a wider counter without extra logic.

Top module: `updn_counter_stage`

## Requirements
- R1: After the system reset (sys_rst_n low), count_o is 0 and both carry_n_o and borrow_n_o are 1.
- R2: A rising edge on up_clk_i while dn_clk_i is high increments count_o, with 15 wrapping to 0. The new value appears on the third system clock edge after the rise.
- R3: A rising edge on dn_clk_i while up_clk_i is high decrements count_o, with 0 wrapping to 15. The latency is the same as in R2.
- R4: A rising edge on one count input while the other count input is low leaves count_o unchanged.
- R5: Rising edges on both count inputs in the same system clock cycle leave count_o unchanged.
- R6: carry_n_o is 0 only while count_o equals 15 and up_clk_i is low. It returns to 1 when up_clk_i rises.
- R7: borrow_n_o is 0 only while count_o equals 0 and dn_clk_i is low. It returns to 1 when dn_clk_i rises.
- R8: While load_n_i is 0, count_o takes the value of preset_i. Edges on the count inputs in that time are discarded.
- R9: While clear_i is 1, count_o is 0, whatever load_n_i and the count inputs do.
- R10: Suppose a count input is held low through a clear or a load and stays low after release. Its next rising edge is counted.
- R11: Two stages form an 8-bit up/down counter when the first stage's carry_n_o and borrow_n_o drive the second stage's up_clk_i and dn_clk_i. The second stage's carry_n_o goes low only at count 255 with up_clk_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low system reset |
| up_clk_i | input | 1 | Count-up clock, acts on its rising edge |
| dn_clk_i | input | 1 | Count-down clock, acts on its rising edge |
| clear_i | input | 1 | Master clear, active high, highest priority |
| load_n_i | input | 1 | Preset load, active low |
| preset_i | input | WIDTH | Value taken by the count during a load |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Terminal count up, active low |
| borrow_n_o | output | 1 | Terminal count down, active low |

## Verification
The bench uses the default WIDTH of 4 and SYNC_STAGES of 2, and chains two stages through their terminal outputs. This gives an 8-bit counter with 256 states. Sweeps of several hundred up and down steps cover every state, including the 255/0 wrap. They also exercise each carry and borrow low phase in both stages against an arithmetic model. The two-flop depth keeps the three-edge count latency short, so the exact cycle of each update can be checked as well.

// File: rtl/updn_pkg.sv
package updn_pkg;

    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_INC   = 3'd1,
        ACT_DEC   = 3'd2,
        ACT_LOAD  = 3'd3,
        ACT_CLEAR = 3'd4
    } act_e;

    // Priority: clear, then load, then a single qualified edge.
    function automatic act_e pick_action(
        input logic clr,
        input logic load,
        input logic up_rise,
        input logic dn_rise,
        input logic up_lvl,
        input logic dn_lvl
    );
        if (clr)                 return ACT_CLEAR;
        if (load)                return ACT_LOAD;
        if (up_rise && dn_rise)  return ACT_HOLD;
        if (up_rise && dn_lvl)   return ACT_INC;
        if (dn_rise && up_lvl)   return ACT_DEC;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= RST_VAL;
                end else begin
                    chain_q[g] <= chain_d[g];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/updn_edge.sv
module updn_edge #(
    parameter int               LANES   = 2,
    parameter logic [LANES-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lvl_i,
    output logic [LANES-1:0] rise_o
);

    logic [LANES-1:0] prev_d;
    logic [LANES-1:0] prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign rise_o[g] = lvl_i[g] & ~prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/updn_core.sv
module updn_core
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    input  logic             up_rise,
    input  logic             dn_rise,
    input  logic             clr_lvl,
    input  logic             load_lvl,
    input  logic [WIDTH-1:0] preset_i,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_n_o,
    output logic             borrow_n_o
);

    localparam logic [WIDTH-1:0] CNT_MAX  = '1;
    localparam logic [WIDTH-1:0] CNT_ZERO = '0;
    localparam logic [WIDTH-1:0] CNT_ONE  = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic             carry_n;
        logic             borrow_n;
    } state_t;

    localparam state_t ST_RESET = '{count: CNT_ZERO, carry_n: 1'b1, borrow_n: 1'b1};

    state_t st_d;
    state_t st_q;
    act_e   act;

    always_comb begin
        st_d = st_q;
        act  = pick_action(clr_lvl, load_lvl, up_rise, dn_rise, up_lvl, dn_lvl);
        unique case (act)
            ACT_CLEAR: st_d.count = CNT_ZERO;
            ACT_LOAD:  st_d.count = preset_i;
            ACT_INC:   st_d.count = st_q.count + CNT_ONE;
            ACT_DEC:   st_d.count = st_q.count - CNT_ONE;
            default:   st_d.count = st_q.count;
        endcase
        // Terminal outputs follow the next count and the present clock level.
        st_d.carry_n  = !((st_d.count == CNT_MAX)  && !up_lvl);
        st_d.borrow_n = !((st_d.count == CNT_ZERO) && !dn_lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o    = st_q.count;
    assign carry_n_o  = st_q.carry_n;
    assign borrow_n_o = st_q.borrow_n;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lvl |=> (count_o == CNT_ZERO)); // R9

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_lvl && !clr_lvl) |=> (count_o == $past(preset_i))); // R8

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_lvl && !load_lvl && up_rise && dn_lvl && !dn_rise)
        |=> (count_o == WIDTH'($past(count_o) + CNT_ONE))); // R2

    AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_lvl && !load_lvl && dn_rise && up_lvl && !up_rise)
        |=> (count_o == WIDTH'($past(count_o) - CNT_ONE))); // R3

    AST_ONE_LOW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_lvl && !load_lvl && ((up_rise && !dn_lvl) || (dn_rise && !up_lvl)))
        |=> $stable(count_o)); // R4

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_lvl && !load_lvl && up_rise && dn_rise) |=> $stable(count_o)); // R5

    AST_CARRY_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n_o |-> (count_o == CNT_MAX)); // R6

    AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n_o |-> (count_o == CNT_ZERO)); // R7

endmodule

// File: rtl/updn_counter_stage.sv
module updn_counter_stage #(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic             up_clk_i,
    input  logic             dn_clk_i,
    input  logic             clear_i,
    input  logic             load_n_i,
    input  logic [WIDTH-1:0] preset_i,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_n_o,
    output logic             borrow_n_o
);

    // Control lanes: [3] load_n, [2] clear, [1] down clock, [0] up clock.
    localparam int          CTRL_W   = 4;
    localparam logic [3:0]  CTRL_RST = 4'b1011;
    localparam int          CLK_LANES = 2;

    logic [CTRL_W-1:0]    ctrl_raw;
    logic [CTRL_W-1:0]    ctrl_s;
    logic [WIDTH-1:0]     preset_s;
    logic [CLK_LANES-1:0] clk_lvl;
    logic [CLK_LANES-1:0] clk_rise;

    assign ctrl_raw = {load_n_i, clear_i, dn_clk_i, up_clk_i};

    updn_sync #(
        .WIDTH  (CTRL_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CTRL_RST)
    ) u_ctrl_sync (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .async_i(ctrl_raw),
        .sync_o (ctrl_s)
    );

    // Data follows the same depth as the load strobe so they stay aligned.
    updn_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES),
        .RST_VAL('0)
    ) u_preset_sync (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .async_i(preset_i),
        .sync_o (preset_s)
    );

    assign clk_lvl = ctrl_s[1:0];

    updn_edge #(
        .LANES  (CLK_LANES),
        .RST_VAL('1)
    ) u_edge (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .lvl_i (clk_lvl),
        .rise_o(clk_rise)
    );

    updn_core #(
        .WIDTH(WIDTH)
    ) u_core (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .up_lvl    (clk_lvl[0]),
        .dn_lvl    (clk_lvl[1]),
        .up_rise   (clk_rise[0]),
        .dn_rise   (clk_rise[1]),
        .clr_lvl   (ctrl_s[2]),
        .load_lvl  (!ctrl_s[3]),
        .preset_i  (preset_s),
        .count_o   (count_o),
        .carry_n_o (carry_n_o),
        .borrow_n_o(borrow_n_o)
    );

    AST_TERM_NOT_BOTH: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !(!carry_n_o && !borrow_n_o)); // R6 R7: max and zero never coincide

endmodule

// File: tb/test_updn_counter_stage.sv
module test_updn_counter_stage;

    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         up = 1'b1;
    logic         dn = 1'b1;
    logic         clr = 1'b0;
    logic         ld_n = 1'b1;
    logic [W-1:0] pre_lo = '0;
    logic [W-1:0] pre_hi = '0;
    logic [W-1:0] q_lo, q_hi;
    logic         cy_lo, bw_lo, cy_hi, bw_hi;

    int nchecks = 0;
    int nfail   = 0;
    int cyc     = 0;
    bit done    = 1'b0;
    int model   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_counter_stage i_updn_counter_stage (
        .clk(clk), .sys_rst_n(rst_n), .up_clk_i(up), .dn_clk_i(dn),
        .clear_i(clr), .load_n_i(ld_n), .preset_i(pre_lo),
        .count_o(q_lo), .carry_n_o(cy_lo), .borrow_n_o(bw_lo));

    updn_counter_stage i_updn_counter_stage_hi (
        .clk(clk), .sys_rst_n(rst_n), .up_clk_i(cy_lo), .dn_clk_i(bw_lo),
        .clear_i(clr), .load_n_i(ld_n), .preset_i(pre_hi),
        .count_o(q_hi), .carry_n_o(cy_hi), .borrow_n_o(bw_hi));

    task automatic chk(input string tag, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int cnt8();
        return {24'd0, q_hi, q_lo};
    endfunction

    task automatic do_load(input int v);
        pre_lo = v[3:0];
        pre_hi = v[7:4];
        ld_n = 1'b0;
        clks(6);
        ld_n = 1'b1;
        clks(6);
        model = v & 255;
    endtask

    task automatic step_up();
        up = 1'b0;
        clks(8);
        chk("R6 carry low phase", int'(cy_lo), (model % 16 == 15) ? 0 : 1);
        chk("R11 upper carry", int'(cy_hi), (model == 255) ? 0 : 1);
        up = 1'b1;
        clks(8);
        model = (model + 1) & 255;
        chk("R2 R11 count up", cnt8(), model);
        chk("R6 carry high after rise", int'(cy_lo), 1);
    endtask

    task automatic step_dn();
        dn = 1'b0;
        clks(8);
        chk("R7 borrow low phase", int'(bw_lo), (model % 16 == 0) ? 0 : 1);
        chk("R11 upper borrow", int'(bw_hi), (model == 0) ? 0 : 1);
        dn = 1'b1;
        clks(8);
        model = (model + 255) & 255;
        chk("R3 R11 count down", cnt8(), model);
        chk("R7 borrow high after rise", int'(bw_lo), 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    initial begin
        clks(4);
        rst_n = 1'b1;
        clks(4);
        chk("R1 reset count", cnt8(), 0);
        chk("R1 reset carry", int'(cy_lo), 1);
        chk("R1 reset borrow", int'(bw_lo), 1);

        // R2 exact latency: new value on third edge after the rise
        do_load(8'h37);
        up = 1'b0;
        clks(6);
        up = 1'b1;
        clks(2);
        chk("R2 not yet after two edges", int'(q_lo), 7);
        clks(1);
        chk("R2 updated on third edge", int'(q_lo), 8);
        clks(6);
        model = 8'h38;

        // R3 exact latency
        dn = 1'b0;
        clks(6);
        dn = 1'b1;
        clks(2);
        chk("R3 not yet after two edges", int'(q_lo), 8);
        clks(1);
        chk("R3 updated on third edge", int'(q_lo), 7);
        clks(6);
        model = 8'h37;

        // R4: up edge while down low is ignored; release of down then counts
        dn = 1'b0;
        clks(6);
        up = 1'b0;
        clks(6);
        up = 1'b1;
        clks(8);
        chk("R4 up edge with down low ignored", cnt8(), 8'h37);
        dn = 1'b1;
        clks(8);
        chk("R4 down release with up high counts", cnt8(), 8'h36);
        model = 8'h36;

        // R5: coincident rising edges
        up = 1'b0;
        dn = 1'b0;
        clks(6);
        up = 1'b1;
        dn = 1'b1;
        clks(8);
        chk("R5 coincident edges hold", cnt8(), 8'h36);

        // R8: load overrides clock edges
        pre_lo = 4'hA;
        pre_hi = 4'h5;
        ld_n = 1'b0;
        clks(5);
        chk("R8 load value", cnt8(), 8'h5A);
        up = 1'b0;
        clks(4);
        up = 1'b1;
        clks(6);
        chk("R8 edge during load discarded", cnt8(), 8'h5A);
        ld_n = 1'b1;
        clks(6);
        chk("R8 after load release", cnt8(), 8'h5A);

        // R10 via load: up held low through load and after
        up = 1'b0;
        pre_lo = 4'hF;
        pre_hi = 4'h2;
        ld_n = 1'b0;
        clks(6);
        chk("R6 carry low at max after load", int'(cy_lo), 0);
        ld_n = 1'b1;
        clks(6);
        up = 1'b1;
        clks(10);
        chk("R10 edge after load counts", cnt8(), 8'h30);

        // R9: clear overrides load and clocks
        pre_lo = 4'h9;
        pre_hi = 4'h9;
        ld_n = 1'b0;
        clr = 1'b1;
        clks(5);
        chk("R9 clear beats load", cnt8(), 0);
        up = 1'b0;
        clks(4);
        up = 1'b1;
        clks(6);
        chk("R9 clear beats up edge", cnt8(), 0);
        ld_n = 1'b1;

        // R10 via clear: down held low through clear and after
        dn = 1'b0;
        clks(6);
        chk("R7 borrow low at zero under clear", int'(bw_lo), 0);
        clr = 1'b0;
        clks(6);
        chk("R9 zero after clear release", cnt8(), 0);
        dn = 1'b1;
        clks(10);
        chk("R10 edge after clear counts and wraps", cnt8(), 255);
        model = 255;

        // R11 sweeps across every state of the 8-bit chain
        do_load(8'hF0);
        for (int i = 0; i < 300; i++) step_up();
        for (int i = 0; i < 300; i++) step_dn();

        finish_run();
    end

endmodule